// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits beside one memory module in a shared-memory multiprocessor and keeps the coherence directory for the blocks that module owns. Each block has an exact record of which caches hold it: one presence bit per cache. It also has a dirty flag, which is set when a single cache holds a modified copy that memory does not yet have.

Caches send read-miss and write requests to a single request port. For a write, the controller first sends invalidations to every other cache that holds the block. It waits for one acknowledgement from each of them and only then sends the write grant. A read of a dirty block first recalls the modified data from its owner, then answers the reader. The controller handles one transaction at a time, and it holds off every new request until the current one has finished.

Top module: `fullmap_dir_ctrl`

## Requirements
- R1: After reset every directory entry is empty and clean, `req_ready` is 1, `inv_valid` is 0 and `rsp_valid` is 0. Memory word `b` holds the value `b`.
- R2: A read of a clean block sends no invalidation. It gets a response with `rsp_grant`=0 and the memory word, and the reader becomes a sharer.
- R3: A write request sends one `inv_valid` pulse to exactly the caches whose presence bit is set, excluding the requester, with `inv_recall`=0.
- R4: `rsp_valid` stays 0 until an acknowledgement has come from every cache that was sent an invalidation or recall. It rises in the cycle after the last such acknowledgement is taken.
- R5: After a write grant (`rsp_grant`=1), the entry holds only the writer and is dirty. A later request from another cache therefore targets the writer alone.
- R6: A read of a dirty block sends one recall (`inv_recall`=1) to the owner only. The data on `ack_data` becomes the memory word, the response carries that data, and the entry becomes clean with owner and reader both present.
- R7: When a cache writes a block it already owns dirty, the grant is issued with no invalidation.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response, so requests stall while a transaction is in flight.
- R9: An acknowledgement from a cache that was not sent an invalidation or recall is ignored and does not count toward completion.
- R10: When another cache writes a dirty block, the owner's acknowledgement data is written back to memory. The grant carries that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_src | input | $clog2(N) | Requesting cache |
| req_write | input | 1 | 1 = write permission, 0 = read miss |
| req_blk | input | $clog2(NBLK) | Block index |
| inv_valid | output | N | Per-cache invalidate/recall pulse |
| inv_recall | output | 1 | 1 = recall data and keep shared copy, 0 = invalidate |
| inv_blk | output | $clog2(NBLK) | Block being invalidated or recalled |
| ack_valid | input | N | Per-cache acknowledgement |
| ack_data | input | DW | Data returned by a dirty owner |
| rsp_valid | output | 1 | Response pulse |
| rsp_dst | output | $clog2(N) | Cache receiving the response |
| rsp_grant | output | 1 | 1 = write grant, 0 = read data |
| rsp_data | output | DW | Block data |

## Verification
The bench uses the default build: four caches, eight blocks and 16-bit data. With only eight blocks, random traffic keeps returning to blocks that already have several sharers or a dirty owner. This brings invalidations to between one and three caches, recalls, and handovers between dirty owners within reach in a few hundred operations. Acknowledgements arrive in random subsets over several cycles, and stray acknowledgements from caches that were not targeted are mixed in. This exercises the counting and the check that the response does not come early.

// File: rtl/fullmap_dir_ctrl.sv
module fullmap_dir_ctrl #(
  parameter int N    = 4,
  parameter int NBLK = 8,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [$clog2(N)-1:0]    req_src,
  input  logic                    req_write,
  input  logic [$clog2(NBLK)-1:0] req_blk,
  output logic [N-1:0]            inv_valid,
  output logic                    inv_recall,
  output logic [$clog2(NBLK)-1:0] inv_blk,
  input  logic [N-1:0]            ack_valid,
  input  logic [DW-1:0]           ack_data,
  output logic                    rsp_valid,
  output logic [$clog2(N)-1:0]    rsp_dst,
  output logic                    rsp_grant,
  output logic [DW-1:0]           rsp_data
);
  localparam int CW = $clog2(N);
  localparam int BW = $clog2(NBLK);
  localparam int KW = $clog2(N + 1);

  typedef enum logic [1:0] {S_IDLE, S_INV, S_WAIT, S_RSP} st_t;

  st_t           st;
  logic [N-1:0]  pres  [NBLK];
  logic [NBLK-1:0] dirty;
  logic [DW-1:0] mem   [NBLK];
  logic [CW-1:0] src_q;
  logic [BW-1:0] blk_q;
  logic          wr_q;
  logic [N-1:0]  tgt_q;
  logic [KW-1:0] cnt_q;

  function automatic logic [KW-1:0] pop(input logic [N-1:0] v);
    logic [KW-1:0] c = '0;
    for (int i = 0; i < N; i++) c = c + KW'(v[i]);
    return c;
  endfunction

  logic [N-1:0]  req_bit, new_tgt, hit;
  logic [KW-1:0] cnt_nxt;

  assign req_bit = N'(1) << req_src;
  assign new_tgt = (req_write || dirty[req_blk]) ? (pres[req_blk] & ~req_bit) : '0;
  assign hit     = ack_valid & tgt_q;
  assign cnt_nxt = cnt_q - pop(hit);

  assign req_ready  = (st == S_IDLE);
  assign inv_valid  = (st == S_INV) ? tgt_q : '0;
  assign inv_recall = ~wr_q;
  assign inv_blk    = blk_q;
  assign rsp_valid  = (st == S_RSP);
  assign rsp_dst    = src_q;
  assign rsp_grant  = wr_q;
  assign rsp_data   = mem[blk_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      src_q <= '0;
      blk_q <= '0;
      wr_q  <= 1'b0;
      tgt_q <= '0;
      cnt_q <= '0;
      dirty <= '0;
      for (int b = 0; b < NBLK; b++) begin
        pres[b] <= '0;
        mem[b]  <= DW'(b);
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          src_q <= req_src;
          blk_q <= req_blk;
          wr_q  <= req_write;
          tgt_q <= new_tgt;
          cnt_q <= pop(new_tgt);
          st    <= (new_tgt != '0) ? S_INV : S_RSP;
        end
        S_INV, S_WAIT: begin
          tgt_q <= tgt_q & ~ack_valid;
          cnt_q <= cnt_nxt;
          if (dirty[blk_q] && hit != '0) mem[blk_q] <= ack_data;
          st <= (cnt_nxt == '0) ? S_RSP : S_WAIT;
        end
        S_RSP: begin
          if (wr_q) begin
            pres[blk_q]  <= N'(1) << src_q;
            dirty[blk_q] <= 1'b1;
          end else begin
            pres[blk_q]  <= pres[blk_q] | (N'(1) << src_q);
            dirty[blk_q] <= 1'b0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_stall_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_inv_excludes_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid != '0 && !inv_recall) |-> ((inv_valid & (N'(1) << rsp_dst)) == '0));

  assert_recall_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid != '0 && inv_recall) |-> $onehot(inv_valid));

  assert_rsp_after_all_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cnt_q == '0 && tgt_q == '0));

  assert_rsp_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_dirty_single_holder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |=> (pres[blk_q] == (N'(1) << src_q) && dirty[blk_q]));
endmodule

// File: tb/fullmap_dir_ctrl_test.sv
module fullmap_dir_ctrl_test;
  localparam int N = 4, NBLK = 8, DW = 16;
  localparam int CW = $clog2(N), BW = $clog2(NBLK);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [CW-1:0] req_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic [N-1:0] ack_valid = '0;
  logic [DW-1:0] ack_data = '0;
  logic req_ready, inv_recall, rsp_valid, rsp_grant;
  logic [N-1:0] inv_valid;
  logic [BW-1:0] inv_blk;
  logic [CW-1:0] rsp_dst;
  logic [DW-1:0] rsp_data;

  fullmap_dir_ctrl #(.N(N), .NBLK(NBLK), .DW(DW)) uut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [N-1:0]  m_pres [NBLK];
  logic          m_dirty[NBLK];
  logic [DW-1:0] m_mem  [NBLK];
  logic [DW-1:0] m_cval [NBLK];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_targets(int src, bit wr, int blk);
    logic [N-1:0] sb = N'(1) << src;
    return (wr || m_dirty[blk]) ? (m_pres[blk] & ~sb) : '0;
  endfunction

  task automatic run_op(int src, bit wr, int blk, bit stray);
    logic [N-1:0] tgt = exp_targets(src, wr, blk);
    logic [N-1:0] rem = tgt;
    logic [DW-1:0] exp_data;
    @(negedge clk);
    chk("R8 ready when idle", req_ready, 1);
    req_valid = 1; req_src = CW'(src); req_write = wr; req_blk = BW'(blk);
    @(negedge clk);
    req_valid = 0;
    chk("R8 stall while busy", req_ready, 0);
    if (tgt != '0) begin
      chk(wr ? "R3 invalidate targets" : "R6 recall target", inv_valid, tgt);
      chk(wr ? "R3 invalidate kind" : "R6 recall kind", inv_recall, !wr);
      chk("R3 inv block", inv_blk, blk);
      for (int it = 0; rem != '0; it++) begin
        logic [N-1:0] sub = N'($urandom) & rem;
        if (it > 3) sub = rem;
        ack_valid = sub | (stray ? (N'($urandom) & ~tgt) : '0);
        ack_data  = m_cval[blk];
        rem = rem & ~sub;
        @(negedge clk);
        ack_valid = '0;
        if (rem != '0) begin
          chk("R4 no response before all acks", rsp_valid, 0);
          if (stray) chk("R9 stray ack ignored", rsp_valid, 0);
        end
      end
    end else begin
      chk(wr ? "R7 no invalidation for owner" : "R2 no invalidation on clean read", inv_valid, 0);
    end
    if (m_dirty[blk] && tgt != '0) m_mem[blk] = m_cval[blk];
    exp_data = m_mem[blk];
    chk("R4 response after acks", rsp_valid, 1);
    chk("R2 response destination", rsp_dst, src);
    chk("R5 response kind", rsp_grant, wr);
    chk(m_dirty[blk] ? (wr ? "R10 written-back data" : "R6 recalled data") : "R2 read data",
        rsp_data, exp_data);
    if (wr) begin
      m_pres[blk] = N'(1) << src; m_dirty[blk] = 1; m_cval[blk] = DW'($urandom);
    end else begin
      m_pres[blk] = m_pres[blk] | (N'(1) << src); m_dirty[blk] = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd1219));
    for (int b = 0; b < NBLK; b++) begin
      m_pres[b] = '0; m_dirty[b] = 0; m_mem[b] = DW'(b); m_cval[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no inv after reset", inv_valid, 0);
    chk("R1 no rsp after reset", rsp_valid, 0);
    run_op(0, 0, 5, 0);
    run_op(1, 0, 5, 0);
    run_op(2, 0, 5, 0);
    run_op(3, 1, 5, 1);
    run_op(3, 1, 5, 0);
    run_op(1, 0, 5, 1);
    run_op(0, 1, 5, 0);
    run_op(2, 1, 5, 1);
    run_op(2, 1, 5, 0);
    for (int k = 0; k < 600; k++) begin
      int s = $urandom_range(N-1);
      int b = $urandom_range(NBLK-1);
      bit w = $urandom_range(1);
      if (!w && m_dirty[b] && m_pres[b][s]) w = 1;
      run_op(s, w, b, $urandom_range(1));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule